// File: doc/BRIEF.md
# Free-Running Timer with Byte-Wide Register Access

This block is a 16-bit up-counting timer for a CPU with an 8-bit data bus. A 2-bit select in the control register picks what advances the count. It can be one of three internal clock-enable pulses, or the rising edge of an external clock pin, which passes through a two-flop synchronizer first. Two 16-bit compare registers, A and B, are compared with the count on every cycle. A hit on A can also return the count to zero. A count that wraps from all ones to zero sets an overflow flag, and that flag can raise an interrupt. A standby input holds the count at zero.

Every 16-bit register is reached as two bytes through one shared 8-bit holding register. Reading a high byte returns the live high byte and, in the same cycle, captures the matching low byte into the holding register, so a later low-byte read returns a consistent pair. Writing a high byte only parks the byte. Writing the low byte then loads all 16 bits in one cycle.

The bus is a single-cycle register strobe. It has no valid/ready pairing and no back-pressure: a strobe is accepted in the cycle it is seen, and read data is valid in that same cycle. Only one of the read and write strobes is raised in a given cycle.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is 0x0000, both compare registers are 0xFFFF, and control, status and `irq_o` are 0. The byte addresses are: 0 count high, 1 count low, 2 compare A high, 3 compare A low, 4 compare B high, 5 compare B low, 6 control, 7 status.
- R2: Control bits [1:0] choose the count source. Values 0, 1 and 2 pick `tick_i[0]`, `tick_i[1]` and `tick_i[2]`. Value 3 picks the external clock. The count rises by one for each enable from the chosen source, and enables from any other source are ignored.
- R3: In external mode the count advances once for each rising edge of `ext_clk_i`, a few cycles after the edge. Holding the pin high causes no further counts.
- R4: Reading a high byte (address 0, 2 or 4) returns the live high byte and captures the low byte of the same register. The next low-byte read returns the captured byte, even if the register has changed in between.
- R5: A high-byte write changes no register and only parks the byte. A low-byte write loads {parked byte, written byte} into the target register in one step.
- R6: Status bit 0 is set while the count equals compare A. Status bit 1 is set while the count equals compare B.
- R7: When control bit 2 is 1, a count enable that arrives while the count equals compare A loads 0x0000 instead of the next value.
- R8: A count enable at 0xFFFF wraps the count to 0x0000 and sets status bit 2.
- R9: `irq_o` is high exactly when status bit 2 and control bit 3 are both 1.
- R10: A status bit is cleared by writing 0 to it after a status read has returned it as 1. Writing 0 without such a read, or writing 1, leaves it set.
- R11: While `standby_i` is high the count is held at 0x0000 and count enables are ignored. The compare registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Holds the count at zero |
| tick_i | input | 3 | Internal clock-enable pulses |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| bus_addr_i | input | 3 | Byte address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench reads a high byte, lets the count step across a byte boundary, and then reads the low byte. A design that does not capture the low byte returns a torn value in that case. It parks a high byte with no following low write and checks that the compare register is unchanged, which catches a design that loads on the high write. It clears status flags with no prior read, and by writing 1, and checks that both leave the flags set; a design that clears too freely fails here. It also checks that a hit on compare A returns the count to zero rather than one, that a wrap sets the overflow flag and raises the interrupt only when it is enabled, and that a held external pin counts only once.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;
  typedef enum logic [2:0] {
    RA_CNT_HI = 3'd0,
    RA_CNT_LO = 3'd1,
    RA_CMPA_HI = 3'd2,
    RA_CMPA_LO = 3'd3,
    RA_CMPB_HI = 3'd4,
    RA_CMPB_LO = 3'd5,
    RA_CTRL = 3'd6,
    RA_STAT = 3'd7
  } reg_addr_e;

  localparam int CTRL_W = 4;
  localparam int CT_CLR = 2;
  localparam int CT_OVIE = 3;
  localparam int N_FLAGS = 3;
  localparam int ST_MA = 0;
  localparam int ST_MB = 1;
  localparam int ST_OV = 2;
endpackage

// File: rtl/frt_edge_sync.sv
`timescale 1ns/1ps
module frt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // the last stage is the delayed copy used for edge detection
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("R3: edge pulse longer than one cycle");
endmodule

// File: rtl/frt_tick_sel.sv
`timescale 1ns/1ps
module frt_tick_sel #(
  parameter int N_INT = 3,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_INT-1:0] tick_i,
  input  logic             ext_rise_i,
  output logic             cnt_en_o
);
  always_comb begin
    cnt_en_o = 1'b0;
    for (int i = 0; i < N_INT; i++) begin
      if (int'(sel_i) == i) cnt_en_o = tick_i[i];
    end
    if (int'(sel_i) >= N_INT) cnt_en_o = ext_rise_i;
  end
endmodule

// File: rtl/frt_byte_bridge.sv
`timescale 1ns/1ps
module frt_byte_bridge #(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_hi_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] lo_snap_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] temp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      temp_o <= '0;
    else if (rd_hi_i) temp_o <= lo_snap_i;
    else if (wr_hi_i) temp_o <= wdata_i;
  end

  a_r4_temp_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_hi_i && !wr_hi_i) |=> $stable(temp_o)) else $error("R4: holding byte moved");
endmodule

// File: rtl/frt_flags.sv
`timescale 1ns/1ps
module frt_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= '0;
      arm_q  <= '0;
    end else if (wr_i) begin
      // only bits seen as 1 and written 0 drop; a new set wins
      flag_o <= (flag_o & ~(arm_q & ~wdata_i)) | set_i;
      arm_q  <= '0;
    end else begin
      flag_o <= flag_o | set_i;
      if (rd_i) arm_q <= arm_q | flag_o;
    end
  end

  a_r10_unarmed_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_o & ~arm_q)) |=> ((flag_o & $past(flag_o & ~arm_q)) == $past(flag_o & ~arm_q)))
    else $error("R10: flag cleared without a prior read");
endmodule

// File: rtl/frt_timer.sv
`timescale 1ns/1ps
module frt_timer
  import frt_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int N_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               standby_i,
  input  logic [N_TICKS-1:0] tick_i,
  input  logic               ext_clk_i,
  input  logic [2:0]         bus_addr_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  output logic               irq_o
);
  localparam int CNT_W = 2 * BUS_W;
  localparam int SEL_W = 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d, cmpa_q, cmpb_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [N_FLAGS-1:0] flags, flag_set;
  logic [BUS_W-1:0]  temp, lo_snap;
  logic ext_rise, cnt_en, rd_hi, wr_hi;
  logic wr_cnt, wr_a, wr_b, wr_ctrl, wr_stat, rd_stat;
  logic match_a, match_b, clr_hit, ovf_set;
  reg_addr_e addr;

  assign addr = reg_addr_e'(bus_addr_i);

  // ---------------- count source ----------------
  frt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i), .rise_o(ext_rise)
  );

  frt_tick_sel #(.N_INT(N_TICKS), .SEL_W(SEL_W)) u_sel (
    .sel_i(ctrl_q[SEL_W-1:0]), .tick_i(tick_i), .ext_rise_i(ext_rise), .cnt_en_o(cnt_en)
  );

  // ---------------- bus decode ----------------
  assign rd_hi = bus_rd_i && (addr == RA_CNT_HI || addr == RA_CMPA_HI || addr == RA_CMPB_HI);
  assign wr_hi = bus_wr_i && (addr == RA_CNT_HI || addr == RA_CMPA_HI || addr == RA_CMPB_HI);
  assign wr_cnt  = bus_wr_i && (addr == RA_CNT_LO);
  assign wr_a    = bus_wr_i && (addr == RA_CMPA_LO);
  assign wr_b    = bus_wr_i && (addr == RA_CMPB_LO);
  assign wr_ctrl = bus_wr_i && (addr == RA_CTRL);
  assign wr_stat = bus_wr_i && (addr == RA_STAT);
  assign rd_stat = bus_rd_i && (addr == RA_STAT);

  always_comb begin
    case (addr)
      RA_CMPA_HI: lo_snap = cmpa_q[BUS_W-1:0];
      RA_CMPB_HI: lo_snap = cmpb_q[BUS_W-1:0];
      default:    lo_snap = cnt_q[BUS_W-1:0];
    endcase
  end

  frt_byte_bridge #(.BUS_W(BUS_W)) u_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_hi_i(rd_hi), .wr_hi_i(wr_hi),
    .lo_snap_i(lo_snap), .wdata_i(bus_wdata_i), .temp_o(temp)
  );

  always_comb begin
    case (addr)
      RA_CNT_HI:  bus_rdata_o = cnt_q[CNT_W-1:BUS_W];
      RA_CMPA_HI: bus_rdata_o = cmpa_q[CNT_W-1:BUS_W];
      RA_CMPB_HI: bus_rdata_o = cmpb_q[CNT_W-1:BUS_W];
      RA_CTRL:    bus_rdata_o = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      RA_STAT:    bus_rdata_o = {{(BUS_W-N_FLAGS){1'b0}}, flags};
      default:    bus_rdata_o = temp;
    endcase
  end

  // ---------------- counter ----------------
  assign match_a = (cnt_q == cmpa_q);
  assign match_b = (cnt_q == cmpb_q);
  assign clr_hit = ctrl_q[CT_CLR] && match_a;
  assign ovf_set = !standby_i && !wr_cnt && cnt_en && !clr_hit && (&cnt_q);

  always_comb begin
    if (standby_i)   cnt_d = '0;
    else if (wr_cnt) cnt_d = {temp, bus_wdata_i};
    else if (cnt_en) cnt_d = clr_hit ? '0 : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmpa_q <= '1;
      cmpb_q <= '1;
      ctrl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_a)    cmpa_q <= {temp, bus_wdata_i};
      if (wr_b)    cmpb_q <= {temp, bus_wdata_i};
      if (wr_ctrl) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
    end
  end

  // ---------------- status ----------------
  always_comb begin
    flag_set        = '0;
    flag_set[ST_MA] = match_a;
    flag_set[ST_MB] = match_b;
    flag_set[ST_OV] = ovf_set;
  end

  frt_flags #(.N(N_FLAGS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set), .rd_i(rd_stat),
    .wr_i(wr_stat), .wdata_i(bus_wdata_i[N_FLAGS-1:0]), .flag_o(flags)
  );

  assign irq_o = flags[ST_OV] & ctrl_q[CT_OVIE];

  // ---------------- assertions ----------------
  a_r11_standby_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (cnt_q == '0)) else $error("R11: count not held at zero");

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !wr_cnt && cnt_en && !clr_hit) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("R2: count did not step by one");

  a_r7_clear_on_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !wr_cnt && cnt_en && clr_hit) |=> (cnt_q == '0))
    else $error("R7: compare A hit did not clear");

  a_r8_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !wr_cnt && cnt_en && !clr_hit && (&cnt_q)) |=> flags[ST_OV])
    else $error("R8: wrap without overflow flag");

  a_r6_match_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == cmpa_q) |=> flags[ST_MA]) else $error("R6: match A flag missing");

  a_r6_match_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == cmpb_q) |=> flags[ST_MB]) else $error("R6: match B flag missing");

  a_r5_hi_write_keeps_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && addr == RA_CMPA_HI) |=> $stable(cmpa_q))
    else $error("R5: high write changed compare A");
endmodule

// File: tb/test_frt_timer.sv
`timescale 1ns/1ps
module test_frt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic [2:0] tick = '0;
  logic       ext_clk = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  frt_timer i_frt_timer (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .tick_i(tick), .ext_clk_i(ext_clk),
    .bus_addr_i(bus_addr), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  // monitor: compares every read strobe against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd && !done) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R4 unexpected read: actual 0x%02h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    step(1);
    bus_rd = 1'b0;
  endtask

  task automatic w16(logic [2:0] a, logic [15:0] v);
    wr(a, v[15:8]);
    wr(a + 3'd1, v[7:0]);
  endtask

  task automatic r16(logic [2:0] a, logic [15:0] v, string t);
    rd(a, v[15:8], t);
    rd(a + 3'd1, v[7:0], t);
  endtask

  task automatic pulse(int idx);
    tick[idx] = 1'b1;
    step(1);
    tick = '0;
    step(1);
  endtask

  task automatic chk_irq(logic e, string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", t, irq, e);
    end
    step(1);
  endtask

  task automatic report();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset values
    chk_irq(1'b0, "R1 irq after reset");
    r16(3'd0, 16'h0000, "R1 count reset");
    r16(3'd2, 16'hFFFF, "R1 compare A reset");
    r16(3'd4, 16'hFFFF, "R1 compare B reset");
    rd(3'd6, 8'h00, "R1 control reset");
    rd(3'd7, 8'h00, "R1 status reset");

    // R4: captured low byte survives a count across the byte boundary
    w16(3'd0, 16'h00FF);
    rd(3'd0, 8'h00, "R4 live high");
    pulse(0);
    rd(3'd1, 8'hFF, "R4 captured low");
    r16(3'd0, 16'h0100, "R4 new pair");

    // R5: a parked high byte alone changes nothing
    w16(3'd4, 16'h0102);
    wr(3'd4, 8'h99);
    r16(3'd4, 16'h0102, "R5 high write only parks");

    // R6 / R10: match B, clear protocol
    pulse(0);
    pulse(0);
    step(1);
    wr(3'd7, 8'h00);
    rd(3'd7, 8'h02, "R10 unread flag kept");
    pulse(0);
    wr(3'd7, 8'h00);
    rd(3'd7, 8'h00, "R10 read then zero clears");
    r16(3'd0, 16'h0103, "R6 count after match B");

    // R2: source selection
    wr(3'd6, 8'h01);
    pulse(0); pulse(0); pulse(2);
    r16(3'd0, 16'h0103, "R2 other sources ignored");
    pulse(1); pulse(1);
    r16(3'd0, 16'h0105, "R2 tick 1 counts");

    // R3: external edges, held high counts once
    wr(3'd6, 8'h03);
    pulse(1);
    for (int i = 0; i < 2; i++) begin
      ext_clk = 1'b1; step(4);
      ext_clk = 1'b0; step(4);
    end
    ext_clk = 1'b1; step(10);
    ext_clk = 1'b0; step(4);
    r16(3'd0, 16'h0108, "R3 external edges");

    // R7 / R6: clear on match A
    wr(3'd6, 8'h04);
    w16(3'd2, 16'h010A);
    pulse(0); pulse(0);
    step(1);
    pulse(0);
    r16(3'd0, 16'h0000, "R7 cleared to zero");
    rd(3'd7, 8'h01, "R6 match A flag");
    wr(3'd7, 8'h00);
    rd(3'd7, 8'h00, "R10 match A cleared");

    // R8 / R9: overflow and interrupt
    wr(3'd6, 8'h00);
    w16(3'd0, 16'hFFFE);
    pulse(0); pulse(0);
    r16(3'd0, 16'h0000, "R8 wrap to zero");
    chk_irq(1'b0, "R9 irq masked");
    wr(3'd6, 8'h08);
    chk_irq(1'b1, "R9 irq enabled");
    rd(3'd7, 8'h04, "R8 overflow flag");
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h04, "R10 writing one keeps flag");
    wr(3'd7, 8'h00);
    chk_irq(1'b0, "R9 irq after clear");
    rd(3'd6, 8'h08, "R9 control readback");

    // R11: standby
    w16(3'd0, 16'h4321);
    standby = 1'b1;
    step(1);
    pulse(0);
    standby = 1'b0;
    r16(3'd0, 16'h0000, "R11 standby zero");
    r16(3'd2, 16'h010A, "R11 compare kept");
    pulse(0);
    r16(3'd0, 16'h0001, "R11 counts after standby");

    step(3);
    report();
  end
endmodule